// File: doc/BRIEF.md
# Protected Page Write Controller

This block owns a 1024-bit user memory held as sixteen 64-bit rows, grouped four rows to a page across four pages. A host changes the memory by loading bytes one at a time into a staging buffer. When the buffer holds a full row, the host asks for a commit to a chosen row. The commit only lands if a 160-bit authorisation code from the host equals the code an external hash engine computed, and if the target page's protection setting allows the write.

Each page has its own two-bit mode. An open page takes the new row as it is. A locked page refuses every write. A page in one-time-program style mode only lets bits fall from 1 to 0, so the stored row becomes the old row ANDed with the new one. An accepted commit starts a programming interval, and the block refuses further commits until that interval ends. Every commit attempt returns a status code that says why a write was or was not taken, and every attempt empties the staging buffer.

A combinational read port returns any row, so software and the bench can see the memory contents directly.

Top module: `ppw_ctrl`

## Requirements
- R1: The memory has 16 rows of 64 bits. Row address bits [3:2] select the page and bits [1:0] select the row inside it. `rd_data` shows row `rd_row` combinationally. After reset every row reads all ones, `status` reads 0 and `busy` is low.
- R2: Each cycle with `ld_valid` high stores `ld_byte` into the next free byte lane of the staging buffer. The first byte lands in bits [7:0] and the eighth in bits [63:56]. Bytes offered once eight are held are ignored.
- R3: A commit attempt made while the buffer holds fewer than 8 bytes is refused with status 4, and memory is left unchanged.
- R4: A commit attempt whose `mac_host` differs from `mac_calc` in any of the 160 bits is refused with status 2, and memory is left unchanged.
- R5: Page mode is `page_mode[2p+1:2p]` for page p. Modes 01 and 11 lock the page, and any commit to a locked page is refused with status 3, leaving memory unchanged.
- R6: Mode 00 (open): an accepted commit replaces the row with the buffer contents and reports status 1.
- R7: Mode 10: an accepted commit stores the old row AND the buffer, so no bit ever rises from 0 to 1. It reports status 1.
- R8: After an accepted commit, `busy` is high for exactly PROG_CYCLES cycles (16 by default). A commit attempt while `busy` is high is refused with status 5.
- R9: The staging buffer is emptied by every commit attempt, whether the attempt is accepted or refused.
- R10: When several refusal reasons apply, the one reported is the first in this order: busy (5), short buffer (4), locked page (3), MAC mismatch (2). `status` updates one cycle after each attempt and otherwise holds its value.
- R11: A byte offered in the same cycle as a commit request is dropped. The commit uses only the bytes loaded before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Byte load strobe |
| ld_byte | input | 8 | Byte to stage |
| commit_req | input | 1 | Commit attempt strobe |
| commit_row | input | 4 | Target row address (page, row) |
| mac_host | input | 160 | Authorisation code supplied by host |
| mac_calc | input | 160 | Expected code from the hash engine |
| page_mode | input | 8 | Two mode bits per page |
| rd_row | input | 4 | Read row address |
| rd_data | output | 64 | Contents of row `rd_row` |
| busy | output | 1 | Programming interval in progress |
| status | output | 3 | Result code of the last commit attempt |

## Verification
A vector table walks commits across all four mode encodings, with full and partial buffers and with matching and mismatched codes. After each commit the bench compares the whole memory, so a write that lands in the wrong row or in a locked page is caught. Combinations that carry several faults at once separate the refusal priority from each single cause. A repeated write to a one-time-program row, using overlapping bit patterns, tells an AND merge apart from an overwrite. Directed cases cover the following:
- a mismatch only in the top code bit;
- surplus bytes;
- a byte offered in the same cycle as a commit;
- a partial load split across a refused commit, which shows the buffer really empties;
- the exact length of the busy window.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

  typedef enum logic [2:0] {
    ST_NONE  = 3'd0,
    ST_OK    = 3'd1,
    ST_MAC   = 3'd2,
    ST_LOCK  = 3'd3,
    ST_SHORT = 3'd4,
    ST_BUSY  = 3'd5
  } ppw_status_e;

  typedef enum logic [1:0] {
    PM_OPEN  = 2'b00,
    PM_LOCK  = 2'b01,
    PM_OTP   = 2'b10,
    PM_LOCK2 = 2'b11
  } ppw_mode_e;

  // A page refuses writes whenever its low mode bit is set
  function automatic logic mode_locked(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_otp(input logic [1:0] m);
    return (m == PM_OTP);
  endfunction

endpackage

// File: rtl/ppw_stage_buf.sv
module ppw_stage_buf #(
  parameter int ROW_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [7:0]             ld_byte,
  input  logic                   clear,
  output logic [ROW_BYTES*8-1:0] row_data,
  output logic                   full
);
  localparam int FW = $clog2(ROW_BYTES + 1);

  logic [FW-1:0] fill_q;
  logic          take;

  // a byte is taken only when no commit is in the same cycle and space remains
  assign take = ld_valid && !clear && (fill_q < FW'(ROW_BYTES));
  assign full = (fill_q == FW'(ROW_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fill_q <= '0;
    else if (clear) fill_q <= '0;
    else if (take)  fill_q <= fill_q + 1'b1;
  end

  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            row_data[i*8 +: 8] <= '0;
      else if (clear)                        row_data[i*8 +: 8] <= '0;
      else if (take && fill_q == FW'(i))     row_data[i*8 +: 8] <= ld_byte;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(ROW_BYTES)); // R2
  AST_BUF_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!full && row_data == '0)); // R9

endmodule

// File: rtl/ppw_auth_gate.sv
module ppw_auth_gate
  import ppw_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int ROWS       = 16,
  parameter int MAC_W      = 160
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_req,
  input  logic [$clog2(ROWS)-1:0]  commit_row,
  input  logic [MAC_W-1:0]         mac_host,
  input  logic [MAC_W-1:0]         mac_calc,
  input  logic [2*PAGES-1:0]       page_mode,
  input  logic                     buf_full,
  input  logic                     busy,
  output ppw_status_e              verdict,
  output logic                     accept,
  output logic                     otp_sel
);
  localparam int RAW = $clog2(ROWS);
  localparam int PGW = $clog2(PAGES);

  logic [1:0]     mode_of [PAGES];
  logic [PGW-1:0] page;
  logic [1:0]     sel_mode;
  logic           mac_match;

  for (genvar p = 0; p < PAGES; p++) begin : g_mode
    assign mode_of[p] = page_mode[2*p +: 2];
  end

  assign page      = commit_row[RAW-1 -: PGW];
  assign sel_mode  = mode_of[page];
  assign mac_match = (mac_host == mac_calc);
  assign otp_sel   = mode_otp(sel_mode);

  always_comb begin
    if (busy)                        verdict = ST_BUSY;
    else if (!buf_full)              verdict = ST_SHORT;
    else if (mode_locked(sel_mode))  verdict = ST_LOCK;
    else if (!mac_match)             verdict = ST_MAC;
    else                             verdict = ST_OK;
  end

  assign accept = commit_req && (verdict == ST_OK);

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && busy) |-> !accept); // R8
  AST_SHORT_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !buf_full) |-> !accept); // R3

endmodule

// File: rtl/ppw_row_store.sv
module ppw_row_store #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(ROWS)-1:0] wr_row,
  input  logic [ROW_W-1:0]        wr_data,
  input  logic                    wr_otp,
  input  logic [$clog2(ROWS)-1:0] rd_row,
  output logic [ROW_W-1:0]        rd_data
);
  localparam int RAW = $clog2(ROWS);

  logic [ROW_W-1:0]      mem_q [ROWS];
  logic [ROWS*ROW_W-1:0] mem_flat;

  // new row content: plain replace, or bits may only fall in one-time mode
  function automatic logic [ROW_W-1:0] merge_row(input logic [ROW_W-1:0] old_v,
                                                 input logic [ROW_W-1:0] new_v,
                                                 input logic             otp);
    return otp ? (old_v & new_v) : new_v;
  endfunction

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem_q[r] <= '1;
      else if (wr_en && wr_row == RAW'(r))  mem_q[r] <= merge_row(mem_q[r], wr_data, wr_otp);
    end
    assign mem_flat[r*ROW_W +: ROW_W] = mem_q[r];
  end

  assign rd_data = mem_q[rd_row];

  AST_OTP_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_otp) |=> ((mem_q[$past(wr_row)] & ~$past(mem_q[wr_row])) == '0)); // R7
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_flat)); // R3

endmodule

// File: rtl/ppw_prog_timer.sv
module ppw_prog_timer #(
  parameter int PROG_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CW'(PROG_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R8
  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/ppw_ctrl.sv
module ppw_ctrl
  import ppw_pkg::*;
#(
  parameter int PAGES         = 4,
  parameter int ROWS_PER_PAGE = 4,
  parameter int ROW_BYTES     = 8,
  parameter int MAC_W         = 160,
  parameter int PROG_CYCLES   = 16
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        ld_valid,
  input  logic [7:0]                                  ld_byte,
  input  logic                                        commit_req,
  input  logic [$clog2(PAGES*ROWS_PER_PAGE)-1:0]      commit_row,
  input  logic [MAC_W-1:0]                            mac_host,
  input  logic [MAC_W-1:0]                            mac_calc,
  input  logic [2*PAGES-1:0]                          page_mode,
  input  logic [$clog2(PAGES*ROWS_PER_PAGE)-1:0]      rd_row,
  output logic [ROW_BYTES*8-1:0]                      rd_data,
  output logic                                        busy,
  output logic [2:0]                                  status
);
  localparam int ROWS  = PAGES * ROWS_PER_PAGE;
  localparam int ROW_W = ROW_BYTES * 8;

  logic [ROW_W-1:0] buf_data;
  logic             buf_full;
  logic             accept;
  logic             otp_sel;
  ppw_status_e      verdict;
  ppw_status_e      status_q;

  ppw_stage_buf #(.ROW_BYTES(ROW_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_byte(ld_byte),
    .clear(commit_req), .row_data(buf_data), .full(buf_full)
  );

  ppw_auth_gate #(.PAGES(PAGES), .ROWS(ROWS), .MAC_W(MAC_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .commit_row(commit_row),
    .mac_host(mac_host), .mac_calc(mac_calc), .page_mode(page_mode),
    .buf_full(buf_full), .busy(busy), .verdict(verdict), .accept(accept),
    .otp_sel(otp_sel)
  );

  ppw_row_store #(.ROWS(ROWS), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_row(commit_row),
    .wr_data(buf_data), .wr_otp(otp_sel), .rd_row(rd_row), .rd_data(rd_data)
  );

  ppw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status_q <= ST_NONE;
    else if (commit_req) status_q <= verdict;
  end

  assign status = status_q;

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_req |=> $stable(status)); // R10
  AST_REFUSE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !accept && !busy) |=> !busy); // R8

endmodule

// File: tb/sim_ppw_ctrl.sv
module sim_ppw_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 16;
  localparam logic [7:0] MODES = 8'hE4; // pg3=11 pg2=10 pg1=01 pg0=00

  typedef struct packed {
    logic [3:0]  row;
    logic [3:0]  nb;
    logic        mac_ok;
    logic [63:0] data;
    logic [2:0]  st;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{4'd0,  4'd8, 1'b1, 64'h0123456789ABCDEF, 3'd1}, // R6 open page
    '{4'd3,  4'd8, 1'b1, 64'h00FF00FF00FF00FF, 3'd1}, // R6 last row of page 0
    '{4'd1,  4'd8, 1'b0, 64'h1111111111111111, 3'd2}, // R4 mismatch
    '{4'd4,  4'd8, 1'b1, 64'h2222222222222222, 3'd3}, // R5 mode 01
    '{4'd13, 4'd8, 1'b1, 64'h3333333333333333, 3'd3}, // R5 mode 11
    '{4'd8,  4'd8, 1'b1, 64'hF0F0F0F0F0F0F0F0, 3'd1}, // R7 first program
    '{4'd8,  4'd8, 1'b1, 64'h0FF00FF00FF00FF0, 3'd1}, // R7 AND merge
    '{4'd2,  4'd5, 1'b1, 64'h4444444444444444, 3'd4}, // R3 short
    '{4'd4,  4'd3, 1'b0, 64'h5555555555555555, 3'd4}, // R10 short over lock and mac
    '{4'd5,  4'd8, 1'b0, 64'h6666666666666666, 3'd3}, // R10 lock over mac
    '{4'd9,  4'd8, 1'b0, 64'h7777777777777777, 3'd2}, // R4 mismatch on otp page
    '{4'd11, 4'd8, 1'b1, 64'hFFFF0000AAAA5555, 3'd1}  // R7 otp from erased row
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_valid = 1'b0;
  logic [7:0]   ld_byte = '0;
  logic         commit_req = 1'b0;
  logic [3:0]   commit_row = '0;
  logic [159:0] mac_host = '0;
  logic [159:0] mac_calc = {5{32'hA5C30F1E}};
  logic [7:0]   page_mode = MODES;
  logic [3:0]   rd_row = '0;
  logic [63:0]  rd_data;
  logic         busy;
  logic [2:0]   status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] model [16];

  ppw_ctrl #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_byte(ld_byte),
    .commit_req(commit_req), .commit_row(commit_row), .mac_host(mac_host),
    .mac_calc(mac_calc), .page_mode(page_mode), .rd_row(rd_row),
    .rd_data(rd_data), .busy(busy), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compares every row against the model; one check
  task automatic check_mem(input string tag);
    int bad = -1;
    logic [63:0] a = '0;
    for (int r = 0; r < 16; r++) begin
      rd_row = 4'(r);
      #1;
      if (rd_data !== model[r] && bad < 0) begin bad = r; a = rd_data; end
    end
    if (bad >= 0) check(tag, a, model[bad]);
    else check(tag, 64'd0, 64'd0);
  endtask

  task automatic load(input logic [63:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ld_valid = 1'b1; ld_byte = d[(i%8)*8 +: 8];
    end
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic commit(input logic [3:0] row);
    @(negedge clk); commit_req = 1'b1; commit_row = row;
    @(negedge clk); commit_req = 1'b0;
  endtask

  task automatic model_write(input logic [3:0] row, input logic [63:0] d);
    if (page_mode[2*row[3:2] +: 2] == 2'b10) model[row] = model[row] & d;
    else model[row] = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) model[r] = '1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 status after reset", 64'(status), 64'd0);
    check("R1 busy after reset", 64'(busy), 64'd0);
    check_mem("R1 memory erased after reset");
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[k]) begin
      wait_idle();
      mac_host = VEC[k].mac_ok ? mac_calc : (mac_calc ^ 160'h1);
      load(VEC[k].data, int'(VEC[k].nb));
      commit(VEC[k].row);
      check($sformatf("R10 vec %0d status", k), 64'(status), 64'(VEC[k].st));
      if (VEC[k].st == 3'd1) model_write(VEC[k].row, VEC[k].data);
      check_mem($sformatf("R6 R7 R5 vec %0d memory", k));
    end

    // R2: surplus bytes dropped
    wait_idle();
    mac_host = mac_calc;
    load(64'hCAFEBABE12345678, 8);
    load(64'hEEEEEEEEEEEEEEEE, 2);
    commit(4'd1);
    model_write(4'd1, 64'hCAFEBABE12345678);
    check("R2 status with surplus bytes", 64'(status), 64'd1);
    check_mem("R2 first eight bytes kept");

    // R8: commit while busy is refused
    load(64'hDEADDEADDEADDEAD, 8);
    check("R8 busy still high", 64'(busy), 64'd1);
    commit(4'd2);
    check("R8 status when busy", 64'(status), 64'd5);
    check_mem("R8 memory unchanged when busy");

    // R8: busy window length
    wait_idle();
    load(64'h0000111122223333, 8);
    commit(4'd2);
    model_write(4'd2, 64'h0000111122223333);
    begin
      int n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check("R8 busy cycles", 64'(n), 64'(PROG));
    end
    check_mem("R6 row 2 written");

    // R9: buffer emptied by refused attempt
    load(64'h9999999999999999, 4);
    commit(4'd0);
    check("R9 short status first half", 64'(status), 64'd4);
    load(64'h8888888888888888, 4);
    commit(4'd0);
    check("R9 buffer emptied by refusal", 64'(status), 64'd4);
    check_mem("R9 memory unchanged");

    // R11: byte in commit cycle dropped
    load(64'h7766554433221100, 7);
    @(negedge clk); ld_valid = 1'b1; ld_byte = 8'h99; commit_req = 1'b1; commit_row = 4'd0;
    @(negedge clk); ld_valid = 1'b0; commit_req = 1'b0;
    check("R11 same-cycle byte dropped", 64'(status), 64'd4);
    check_mem("R11 memory unchanged");

    // R4: mismatch only in top bit
    mac_host = mac_calc ^ (160'h1 << 159);
    load(64'h1234123412341234, 8);
    commit(4'd0);
    check("R4 top bit mismatch", 64'(status), 64'd2);
    check_mem("R4 memory unchanged");

    // R10: status holds between attempts
    repeat (5) @(negedge clk);
    check("R10 status holds", 64'(status), 64'd2);

    // R5/R6: page 1 reopened by mode change
    page_mode = MODES & 8'hF3;
    mac_host = mac_calc;
    load(64'hABCDEF0011223344, 8);
    commit(4'd4);
    model_write(4'd4, 64'hABCDEF0011223344);
    check("R6 reopened page accepted", 64'(status), 64'd1);
    check_mem("R6 reopened page written");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule